// File: doc/BRIEF.md
# Out-of-Order Completion Retire Ring

This block keeps a local circular buffer of packet slots and tracks them with three free-running indices. The write index marks allocation, the dispatch index marks hand-off to a consumer, and the read index marks retirement. A producer asks for a number of slots in one request. The block grants as many as are free and returns the first granted slot. Slots are then dispatched strictly in order. A consumer may finish them in any order by naming a slot index on the completion input.

Each slot has a completion bit. The read index only moves over a contiguous run of completed slots, starting at the oldest outstanding one. The block raises a pulse in every cycle in which the read index moved, so a host-visible read pointer needs updating only at those moments. Each slot also holds a payload word and a header-valid flag. The payload word and the header-valid flag of the slot at the dispatch index are presented to the consumer.

Top module: `ooo_retire_ring`

## Requirements
- R1: After reset the write, dispatch and read indices are zero. `free_cnt` equals the slot count, and `disp_pending`, `rd_moved`, `alloc_done` and `cmpl_err` are low.
- R2: After reset every slot header is invalid. A payload write to a slot marks its header valid, and retiring the slot marks it invalid again. A write wins when both happen to the same slot in the same cycle. `disp_hdr_ok` and `disp_data` show the header flag and payload of the slot at the dispatch index, two cycles after a payload write to that slot.
- R3: A request with `alloc_req` high pulses `alloc_done` on the next cycle. `alloc_gnt` is then the smaller of `alloc_cnt` and the free count, and it is zero when the buffer is full. `alloc_base` is the slot at the old write index, and the write index advances by the grant.
- R4: `free_cnt` equals the slot count minus the difference between the write index and the read index.
- R5: A completion sets the completion bit of the named slot. While the bit at the read slot is set, the block clears it and advances the read index by one, at one slot per cycle. The first advance comes two cycles after the completion input. Completions of younger slots wait until every older slot has completed.
- R6: `rd_moved` is high exactly in the cycles after the read index advanced.
- R7: `disp_pending` is high while the dispatch index differs from the write index. `disp_adv` advances the dispatch index by one only when `disp_pending` is high, and it is ignored otherwise. `disp_slot` is the low bits of the dispatch index.
- R8: Indices are one bit wider than the slot number and wrap modulo twice the slot count. A full buffer (free count 0) and an empty buffer (free count equal to the slot count) are therefore told apart, and the dispatch index never passes the write index.
- R9: A completion for a slot outside the range from the read index up to the dispatch index pulses `cmpl_err` on the next cycle and changes no completion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_cnt | input | AW+1 | Number of slots requested |
| alloc_done | output | 1 | Grant response valid, one cycle after request |
| alloc_gnt | output | AW+1 | Number of slots granted |
| alloc_base | output | AW | First granted slot |
| free_cnt | output | AW+1 | Slots currently free |
| disp_adv | input | 1 | Dispatch-advance strobe |
| disp_pending | output | 1 | At least one allocated slot not yet dispatched |
| disp_slot | output | AW | Slot at the dispatch index |
| disp_hdr_ok | output | 1 | Header-valid flag of the dispatch slot |
| disp_data | output | DW | Payload of the dispatch slot |
| pl_wr_en | input | 1 | Payload write enable |
| pl_wr_slot | input | AW | Payload write slot |
| pl_wr_data | input | DW | Payload write data |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_slot | input | AW | Slot that completed |
| cmpl_err | output | 1 | Completion was outside the outstanding range |
| rd_idx | output | AW+1 | Read (retire) index |
| rd_moved | output | 1 | Read index advanced this cycle |

## Verification
The assertions check some properties on every cycle. The occupancy never exceeds the slot count, and the dispatch index never passes the write index. The read index moves by zero or one per cycle, and `rd_moved` tracks every such move. A completion bit is never held for a slot outside the outstanding range, and a dispatch index does not move with nothing pending. A retired slot loses its header flag. Only the bench scenarios can show that retirement waits for the oldest slot, and that a run of out-of-order completions then drains in the right sequence. The bench scenarios also cover grant clipping at full, wrap of the indices across twice the slot count, and rejection of stale or undispatched completions.

// File: rtl/ooo_ring_pkg.sv
package ooo_ring_pkg;
  // Classification of a completion request against the outstanding range
  typedef enum logic [1:0] {
    CV_NONE   = 2'd0,
    CV_ACCEPT = 2'd1,
    CV_REJECT = 2'd2
  } cmpl_verdict_e;
endpackage

// File: rtl/ooo_ring_alloc.sv
module ooo_ring_alloc #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic [AW:0]   alloc_cnt,
  input  logic [AW:0]   rd_idx,
  output logic [AW:0]   wr_idx,
  output logic [AW:0]   free_cnt,
  output logic          alloc_done,
  output logic [AW:0]   alloc_gnt,
  output logic [AW-1:0] alloc_base
);
  localparam int unsigned IW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [IW-1:0] used;
  logic [IW-1:0] gnt;

  assign used     = wr_idx - rd_idx;
  assign free_cnt = DEPTH_W - used;
  assign gnt      = (alloc_cnt < free_cnt) ? alloc_cnt : free_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx     <= '0;
      alloc_done <= 1'b0;
      alloc_gnt  <= '0;
      alloc_base <= '0;
    end else begin
      alloc_done <= alloc_req;
      if (alloc_req) begin
        wr_idx     <= wr_idx + gnt;
        alloc_gnt  <= gnt;
        alloc_base <= wr_idx[AW-1:0];
      end
    end
  end

  // R3: a grant never exceeds the request nor the space that was free
  a_r3_gnt_bounded: assert property (@(posedge clk) disable iff (rst)
    alloc_req |=> (alloc_gnt <= $past(alloc_cnt)) && (alloc_gnt <= $past(free_cnt)));

  // R3: the write index moves by exactly the reported grant
  a_r3_wr_by_gnt: assert property (@(posedge clk) disable iff (rst)
    alloc_req |=> (wr_idx == $past(wr_idx) + alloc_gnt));
endmodule

// File: rtl/ooo_ring_track.sv
module ooo_ring_track
  import ooo_ring_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   wr_idx,
  input  logic          disp_adv,
  input  logic          cmpl_valid,
  input  logic [AW-1:0] cmpl_slot,
  output logic [AW:0]   disp_idx,
  output logic [AW:0]   disp_idx_nxt,
  output logic          disp_pending,
  output logic [AW:0]   rd_idx,
  output logic          rd_moved,
  output logic          cmpl_err,
  output logic          retire_fire,
  output logic [AW-1:0] retire_slot
);
  localparam int unsigned IW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] done_q, done_d;
  logic             disp_go;
  logic [AW-1:0]    off;
  logic [IW-1:0]    span;
  logic             in_rng;
  cmpl_verdict_e    verdict;

  assign disp_pending = (disp_idx != wr_idx);
  assign disp_go      = disp_adv && disp_pending;
  assign disp_idx_nxt = disp_idx + IW'(disp_go);

  assign retire_slot  = rd_idx[AW-1:0];
  assign retire_fire  = done_q[retire_slot];

  assign off    = cmpl_slot - retire_slot;
  assign span   = disp_idx - rd_idx;
  assign in_rng = ({1'b0, off} < span);

  always_comb begin
    if (!cmpl_valid)  verdict = CV_NONE;
    else if (in_rng)  verdict = CV_ACCEPT;
    else              verdict = CV_REJECT;
  end

  always_comb begin
    done_d = done_q;
    if (verdict == CV_ACCEPT) done_d[cmpl_slot] = 1'b1;
    if (retire_fire)          done_d[retire_slot] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_idx <= '0;
      rd_idx   <= '0;
      done_q   <= '0;
      rd_moved <= 1'b0;
      cmpl_err <= 1'b0;
    end else begin
      disp_idx <= disp_idx_nxt;
      rd_idx   <= rd_idx + IW'(retire_fire);
      done_q   <= done_d;
      rd_moved <= retire_fire;
      cmpl_err <= (verdict == CV_REJECT);
    end
  end

  // R5: the read index steps by at most one slot per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_idx == $past(rd_idx)) || (rd_idx == $past(rd_idx) + IW'(1)));

  // R6: the move pulse coincides with every change of the read index
  a_r6_moved_matches: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_moved == (rd_idx != $past(rd_idx))));

  // R7: with nothing pending the dispatch index holds
  a_r7_no_idle_dispatch: assert property (@(posedge clk) disable iff (rst)
    !disp_pending |=> $stable(disp_idx));

  // R9: completion bits only exist for outstanding slots
  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    a_r9_done_in_range: assert property (@(posedge clk) disable iff (rst)
      done_q[i] |-> ({1'b0, AW'(i) - rd_idx[AW-1:0]} < (disp_idx - rd_idx)));
  end
endmodule

// File: rtl/ooo_ring_slots.sv
module ooo_ring_slots #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_slot,
  input  logic [AW-1:0] rd_slot,
  output logic [DW-1:0] rd_data,
  output logic          rd_hdr_ok
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] hdr_q, hdr_d;

  // Payload: no reset, registered read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
    rd_data <= mem[rd_slot];
  end

  always_comb begin
    hdr_d = hdr_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_en && (clr_slot == AW'(i))) hdr_d[i] = 1'b0;
      if (wr_en && (wr_slot == AW'(i)))   hdr_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q     <= '0;
      rd_hdr_ok <= 1'b0;
    end else begin
      hdr_q     <= hdr_d;
      rd_hdr_ok <= hdr_q[rd_slot];
    end
  end

  // R2: a retired slot loses its header unless rewritten in the same cycle
  a_r2_retire_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(wr_en && (wr_slot == clr_slot))) |=> !hdr_q[$past(clr_slot)]);

  // R2: a payload write always leaves the header valid
  a_r2_write_sets: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hdr_q[$past(wr_slot)]);
endmodule

// File: rtl/ooo_retire_ring.sv
module ooo_retire_ring #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic [AW:0]   alloc_cnt,
  output logic          alloc_done,
  output logic [AW:0]   alloc_gnt,
  output logic [AW-1:0] alloc_base,
  output logic [AW:0]   free_cnt,
  input  logic          disp_adv,
  output logic          disp_pending,
  output logic [AW-1:0] disp_slot,
  output logic          disp_hdr_ok,
  output logic [DW-1:0] disp_data,
  input  logic          pl_wr_en,
  input  logic [AW-1:0] pl_wr_slot,
  input  logic [DW-1:0] pl_wr_data,
  input  logic          cmpl_valid,
  input  logic [AW-1:0] cmpl_slot,
  output logic          cmpl_err,
  output logic [AW:0]   rd_idx,
  output logic          rd_moved
);
  localparam int unsigned IW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [IW-1:0] wr_idx;
  logic [IW-1:0] disp_idx, disp_idx_nxt;
  logic          retire_fire;
  logic [AW-1:0] retire_slot;

  ooo_ring_alloc #(.AW(AW)) u_alloc (
    .clk        (clk),
    .rst        (rst),
    .alloc_req  (alloc_req),
    .alloc_cnt  (alloc_cnt),
    .rd_idx     (rd_idx),
    .wr_idx     (wr_idx),
    .free_cnt   (free_cnt),
    .alloc_done (alloc_done),
    .alloc_gnt  (alloc_gnt),
    .alloc_base (alloc_base)
  );

  ooo_ring_track #(.AW(AW)) u_track (
    .clk          (clk),
    .rst          (rst),
    .wr_idx       (wr_idx),
    .disp_adv     (disp_adv),
    .cmpl_valid   (cmpl_valid),
    .cmpl_slot    (cmpl_slot),
    .disp_idx     (disp_idx),
    .disp_idx_nxt (disp_idx_nxt),
    .disp_pending (disp_pending),
    .rd_idx       (rd_idx),
    .rd_moved     (rd_moved),
    .cmpl_err     (cmpl_err),
    .retire_fire  (retire_fire),
    .retire_slot  (retire_slot)
  );

  ooo_ring_slots #(.AW(AW), .DW(DW)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (pl_wr_en),
    .wr_slot   (pl_wr_slot),
    .wr_data   (pl_wr_data),
    .clr_en    (retire_fire),
    .clr_slot  (retire_slot),
    .rd_slot   (disp_idx_nxt[AW-1:0]),
    .rd_data   (disp_data),
    .rd_hdr_ok (disp_hdr_ok)
  );

  assign disp_slot = disp_idx[AW-1:0];

  // R8: occupancy never exceeds the slot count
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (wr_idx - rd_idx) <= DEPTH_W);

  // R8: dispatch stays between retire and allocate
  a_r8_disp_order: assert property (@(posedge clk) disable iff (rst)
    (disp_idx - rd_idx) <= (wr_idx - rd_idx));
endmodule

// File: tb/tb_ooo_retire_ring.sv
module tb_ooo_retire_ring;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int IW = AW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic [AW:0]   alloc_cnt = '0;
  logic          alloc_done;
  logic [AW:0]   alloc_gnt;
  logic [AW-1:0] alloc_base;
  logic [AW:0]   free_cnt;
  logic          disp_adv = 1'b0;
  logic          disp_pending;
  logic [AW-1:0] disp_slot;
  logic          disp_hdr_ok;
  logic [DW-1:0] disp_data;
  logic          pl_wr_en = 1'b0;
  logic [AW-1:0] pl_wr_slot = '0;
  logic [DW-1:0] pl_wr_data = '0;
  logic          cmpl_valid = 1'b0;
  logic [AW-1:0] cmpl_slot = '0;
  logic          cmpl_err;
  logic [AW:0]   rd_idx;
  logic          rd_moved;

  ooo_retire_ring #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_cnt(alloc_cnt), .alloc_done(alloc_done),
    .alloc_gnt(alloc_gnt), .alloc_base(alloc_base), .free_cnt(free_cnt),
    .disp_adv(disp_adv), .disp_pending(disp_pending), .disp_slot(disp_slot),
    .disp_hdr_ok(disp_hdr_ok), .disp_data(disp_data),
    .pl_wr_en(pl_wr_en), .pl_wr_slot(pl_wr_slot), .pl_wr_data(pl_wr_data),
    .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .cmpl_err(cmpl_err),
    .rd_idx(rd_idx), .rd_moved(rd_moved)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;
  logic finished = 1'b0;

  typedef struct packed {
    logic [IW-1:0] gnt;
    logic [AW-1:0] base;
  } alloc_exp_t;

  alloc_exp_t    alloc_q[$];
  logic [IW-1:0] retire_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected grant and retire items as the design reports them
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (alloc_done) begin
        if (alloc_q.size() == 0) chk("R3 unexpected grant", 32'(alloc_gnt), 32'hDEAD);
        else begin
          alloc_exp_t e;
          e = alloc_q.pop_front();
          chk("R3 grant count", 32'(alloc_gnt), 32'(e.gnt));
          chk("R3 grant base", 32'(alloc_base), 32'(e.base));
        end
      end
      if (rd_moved) begin
        if (retire_q.size() == 0) chk("R5 unexpected retire", 32'(rd_idx), 32'hDEAD);
        else chk("R6 retire index", 32'(rd_idx), 32'(retire_q.pop_front()));
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_alloc(int cnt, int egnt, int ebase);
    alloc_exp_t e;
    e.gnt  = IW'(egnt);
    e.base = AW'(ebase);
    alloc_q.push_back(e);
    @(negedge clk);
    alloc_req = 1'b1;
    alloc_cnt = IW'(cnt);
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic do_disp();
    @(negedge clk);
    disp_adv = 1'b1;
    @(negedge clk);
    disp_adv = 1'b0;
  endtask

  task automatic do_cmpl(int slot);
    @(negedge clk);
    cmpl_valid = 1'b1;
    cmpl_slot  = AW'(slot);
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic do_write(int slot, int data);
    @(negedge clk);
    pl_wr_en   = 1'b1;
    pl_wr_slot = AW'(slot);
    pl_wr_data = DW'(data);
    @(negedge clk);
    pl_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    mon_on = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 free count", 32'(free_cnt), 32'd8);
    chk("R1 pending", 32'(disp_pending), 32'd0);
    chk("R1 read index", 32'(rd_idx), 32'd0);
    chk("R1 moved", 32'(rd_moved), 32'd0);
    chk("R1 dispatch slot", 32'(disp_slot), 32'd0);
    chk("R1 alloc done", 32'(alloc_done), 32'd0);
    chk("R1 cmpl err", 32'(cmpl_err), 32'd0);
    // R2 headers invalid after reset
    chk("R2 header after reset", 32'(disp_hdr_ok), 32'd0);

    for (int i = 0; i < 5; i++) do_write(i, 16'hA0 + i);
    cyc(2);
    chk("R2 header after write", 32'(disp_hdr_ok), 32'd1);
    chk("R2 payload slot 0", 32'(disp_data), 32'hA0);

    // R3/R4 allocation and clipping
    do_alloc(3, 3, 0);
    chk("R4 free after 3", 32'(free_cnt), 32'd5);
    chk("R7 pending", 32'(disp_pending), 32'd1);
    do_alloc(10, 5, 3);
    chk("R4 free when full", 32'(free_cnt), 32'd0);
    do_alloc(2, 0, 0);
    chk("R3 full stays full", 32'(free_cnt), 32'd0);

    // R7 in-order dispatch
    for (int i = 0; i < 4; i++) do_disp();
    chk("R7 dispatch slot", 32'(disp_slot), 32'd4);
    chk("R7 still pending", 32'(disp_pending), 32'd1);
    chk("R2 payload slot 4", 32'(disp_data), 32'hA4);

    // R9 completion of an undispatched slot
    do_cmpl(5);
    chk("R9 error pulse", 32'(cmpl_err), 32'd1);
    cyc(2);
    chk("R9 no retire", 32'(rd_idx), 32'd0);

    // R5 out-of-order completions wait for the oldest
    do_cmpl(2);
    chk("R9 valid completion no error", 32'(cmpl_err), 32'd0);
    do_cmpl(1);
    cyc(3);
    chk("R5 waits for oldest", 32'(rd_idx), 32'd0);
    retire_q.push_back(4'd1);
    retire_q.push_back(4'd2);
    retire_q.push_back(4'd3);
    do_cmpl(0);
    cyc(4);
    chk("R5 run retired", 32'(rd_idx), 32'd3);
    chk("R4 free after retire", 32'(free_cnt), 32'd3);

    // R7 drain dispatch, then an ignored strobe
    for (int i = 0; i < 4; i++) do_disp();
    chk("R7 dispatch wrapped", 32'(disp_slot), 32'd0);
    chk("R7 nothing pending", 32'(disp_pending), 32'd0);
    do_disp();
    chk("R7 idle strobe ignored", 32'(disp_slot), 32'd0);
    cyc(2);
    // R2 slot 0 was retired, so its header is invalid again
    chk("R2 header cleared by retire", 32'(disp_hdr_ok), 32'd0);

    retire_q.push_back(4'd4);
    do_cmpl(3);
    do_cmpl(7);
    do_cmpl(6);
    do_cmpl(5);
    cyc(2);
    chk("R5 partial retire", 32'(rd_idx), 32'd4);
    for (int i = 5; i <= 8; i++) retire_q.push_back(IW'(i));
    do_cmpl(4);
    cyc(6);
    chk("R8 read index past slot count", 32'(rd_idx), 32'd8);
    chk("R8 empty free count", 32'(free_cnt), 32'd8);

    // R8 allocate full depth across the wrap
    do_alloc(8, 8, 0);
    chk("R8 full after wrap", 32'(free_cnt), 32'd0);
    chk("R8 pending after wrap", 32'(disp_pending), 32'd1);
    chk("R7 ignored strobe left index", 32'(disp_slot), 32'd0);

    // R9 stale completion with nothing dispatched
    do_cmpl(0);
    chk("R9 stale completion error", 32'(cmpl_err), 32'd1);
    cyc(2);
    chk("R9 stale ignored", 32'(rd_idx), 32'd8);

    cyc(2);
    chk("R3 all grants seen", 32'(alloc_q.size()), 32'd0);
    chk("R6 all retires seen", 32'(retire_q.size()), 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule